// File: doc/BRIEF.md
# Layer priority pixel mixer

This block chooses, for each pixel of a scan line, which of three layers shows: a sprite, foreground plane A (or the window that can replace it), or background plane B. If none of them is opaque, a fixed background colour shows. Each layer pixel is a 7-bit word. Bit 6 is a priority flag, bits 5:4 select a palette, and bits 3:0 are a colour index. Index 0 means transparent. The block outputs a 6-bit colour-RAM address, a shade select and a 6-bit source tag for debug colouring. These outputs are registered and come with a valid strobe.

Plane pixels are not fed in directly. A tile fetcher writes them into two 32-entry circular line buffers, one per plane. The mixer reads each buffer at a running offset minus the plane's fine horizontal scroll. Sprite pixels arrive on the pixel strobe. A mode input switches between plain priority mixing and shadow/highlight mixing. In shadow/highlight mode two sprite colour values act as shading operators and are never drawn. Pixels that no priority layer claims are drawn darkened.

Top module: `lyr_mixer`

## Requirements
- R1: A layer pixel whose bits 3:0 are 0 is transparent and never selected, whatever its priority bit 6 or palette bits 5:4. When all three layers are transparent, the output colour is `bg_color_i` and the source is background.
- R2: In normal mode the first opaque layer in this order wins: sprite with priority, plane A with priority, plane B with priority, sprite, plane A, plane B. The output colour is the winner's bits 5:0.
- R3: In normal mode `shade_o` is always 0 (normal).
- R4: In shadow/highlight mode, a sprite whose bits 5:0 equal 0x3F sets `shade_o` to 1 (shadow), and 0x3E sets it to 2 (highlight). The bit 6 value does not matter. The colour then comes from the planes and the background in the order priority A, priority B, A, B, background. The sprite is never the source.
- R5: In shadow/highlight mode without an operator, selection follows R2. The pixel is shadowed (`shade_o`=1) unless a priority sprite, priority plane A or priority plane B pixel won.
- R6: In shadow/highlight mode, a non-priority sprite pixel that wins with bits 3:0 equal to 0xE is shown unshaded (`shade_o`=0).
- R7: Plane A is read at the running offset minus `hscroll_a_i`, or with no subtraction while `window_i` is 1. Plane B is read at the running offset minus `hscroll_b_i`. Both are modulo 32.
- R8: `line_start_i` sets the running offset to 0. Each valid pixel advances it by one. The offset wraps modulo 32, and the plane bases step by 16 after every 16 pixels.
- R9: `tag_o` bits 2:0 name the source: 0 background, 1 plane A, 2 window, 3 plane B, 4 sprite. Bit 3 is the winner's priority bit, bit 4 marks shadow and bit 5 marks highlight.
- R10: The outputs follow the pixel strobe by exactly one clock, and `valid_o` is 0 after a cycle without a strobe. Reset clears all outputs and both line buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Restart the running offset and plane bases |
| wr_en_i | input | 1 | Line-buffer write strobe |
| wr_plane_b_i | input | 1 | Write target: 0 plane A, 1 plane B |
| wr_addr_i | input | 5 | Line-buffer write address |
| wr_pix_i | input | 7 | Plane pixel to store |
| pix_valid_i | input | 1 | Mix one pixel this cycle |
| spr_pix_i | input | 7 | Sprite pixel |
| sh_mode_i | input | 1 | 1 selects shadow/highlight mixing |
| window_i | input | 1 | Plane A input is the window (no fine scroll) |
| hscroll_a_i | input | 4 | Plane A fine scroll |
| hscroll_b_i | input | 4 | Plane B fine scroll |
| bg_color_i | input | 6 | Background colour-RAM index |
| valid_o | output | 1 | Output pixel valid |
| cram_idx_o | output | 6 | Colour-RAM index |
| shade_o | output | 2 | 0 normal, 1 shadow, 2 highlight |
| tag_o | output | 6 | Source tag (R9) |

## Verification
If the offset counter or a plane base is off, every following pixel of that line reads a neighbouring buffer entry. The bench fills the buffers with 32 distinct colours, so the fault shows on the very next output. A scroll subtraction that is wrong, or that is applied in window mode, shows the same way. A precedence or shade error shows within one clock of the pixel that triggers it. The sweep covers every combination of a sample set of layer values that includes transparent-with-priority, both operators and index 0xE.

// File: rtl/lyr_mix_pkg.sv
package lyr_mix_pkg;
  typedef struct packed {
    logic       pri;
    logic [1:0] pal;
    logic [3:0] idx;
  } pix_t;

  typedef enum logic [1:0] {
    SHD_NORM  = 2'd0,
    SHD_DARK  = 2'd1,
    SHD_LIGHT = 2'd2
  } shade_e;

  typedef enum logic [2:0] {
    SRC_BG  = 3'd0,
    SRC_A   = 3'd1,
    SRC_WIN = 3'd2,
    SRC_B   = 3'd3,
    SRC_SPR = 3'd4
  } src_e;

  typedef struct packed {
    logic light;
    logic dark;
    logic pri;
    src_e src;
  } tag_t;

  localparam logic [5:0] OP_SHADOW = 6'h3F;
  localparam logic [5:0] OP_LIGHT  = 6'h3E;
endpackage

// File: rtl/lyr_line_buf.sv
module lyr_line_buf
  import lyr_mix_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  pix_t          wdata_i,
  input  logic [AW-1:0] raddr_i,
  output pix_t          rdata_o
);
  pix_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lyr_prio_resolve.sv
module lyr_prio_resolve
  import lyr_mix_pkg::*;
(
  input  logic       sh_mode_i,
  input  logic       win_i,
  input  pix_t       spr_i,
  input  pix_t       a_i,
  input  pix_t       b_i,
  input  logic [5:0] bg_i,
  output logic [5:0] color_o,
  output shade_e     shade_o,
  output tag_t       tag_o
);
  logic s_op, a_op, b_op, op_hit, pri_win;
  src_e a_src, src;
  logic pri;

  always_comb begin
    s_op    = spr_i.idx != 4'd0;
    a_op    = a_i.idx != 4'd0;
    b_op    = b_i.idx != 4'd0;
    op_hit  = sh_mode_i && ({spr_i.pal, spr_i.idx} == OP_SHADOW ||
                            {spr_i.pal, spr_i.idx} == OP_LIGHT);
    a_src   = win_i ? SRC_WIN : SRC_A;
    pri_win = 1'b0;
    color_o = bg_i;
    src     = SRC_BG;
    pri     = 1'b0;
    if (op_hit) begin
      // operator sprite: visible pixel from planes only
      if (a_i.pri && a_op)      begin color_o = {a_i.pal, a_i.idx}; src = a_src; pri = 1'b1; end
      else if (b_i.pri && b_op) begin color_o = {b_i.pal, b_i.idx}; src = SRC_B; pri = 1'b1; end
      else if (a_op)            begin color_o = {a_i.pal, a_i.idx}; src = a_src; end
      else if (b_op)            begin color_o = {b_i.pal, b_i.idx}; src = SRC_B; end
    end else begin
      if (spr_i.pri && s_op) begin
        color_o = {spr_i.pal, spr_i.idx}; src = SRC_SPR; pri = 1'b1; pri_win = 1'b1;
      end else if (a_i.pri && a_op) begin
        color_o = {a_i.pal, a_i.idx}; src = a_src; pri = 1'b1; pri_win = 1'b1;
      end else if (b_i.pri && b_op) begin
        color_o = {b_i.pal, b_i.idx}; src = SRC_B; pri = 1'b1; pri_win = 1'b1;
      end else if (s_op) begin
        color_o = {spr_i.pal, spr_i.idx}; src = SRC_SPR;
      end else if (a_op) begin
        color_o = {a_i.pal, a_i.idx}; src = a_src;
      end else if (b_op) begin
        color_o = {b_i.pal, b_i.idx}; src = SRC_B;
      end
    end

    if (!sh_mode_i)                              shade_o = SHD_NORM;
    else if (op_hit)                             shade_o = spr_i.idx[0] ? SHD_DARK : SHD_LIGHT;
    else if (pri_win)                            shade_o = SHD_NORM;
    else if (src == SRC_SPR && spr_i.idx == 4'hE) shade_o = SHD_NORM;
    else                                         shade_o = SHD_DARK;

    tag_o.src   = src;
    tag_o.pri   = pri;
    tag_o.dark  = shade_o == SHD_DARK;
    tag_o.light = shade_o == SHD_LIGHT;
  end
endmodule

// File: rtl/lyr_mixer.sv
module lyr_mixer
  import lyr_mix_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int GROUP_PIX = 16,
  parameter int FINE_W    = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         line_start_i,
  input  logic                         wr_en_i,
  input  logic                         wr_plane_b_i,
  input  logic [$clog2(BUF_DEPTH)-1:0] wr_addr_i,
  input  logic [6:0]                   wr_pix_i,
  input  logic                         pix_valid_i,
  input  logic [6:0]                   spr_pix_i,
  input  logic                         sh_mode_i,
  input  logic                         window_i,
  input  logic [FINE_W-1:0]            hscroll_a_i,
  input  logic [FINE_W-1:0]            hscroll_b_i,
  input  logic [5:0]                   bg_color_i,
  output logic                         valid_o,
  output logic [5:0]                   cram_idx_o,
  output logic [1:0]                   shade_o,
  output logic [5:0]                   tag_o
);
  localparam int AW    = $clog2(BUF_DEPTH);
  localparam int POS_W = $clog2(GROUP_PIX);

  logic [POS_W-1:0] pos_q;
  logic [AW-1:0]    base_a_q, base_b_q;
  logic [AW-1:0]    raddr [2];
  pix_t             rdata [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0; base_a_q <= '0; base_b_q <= '0;
    end else if (line_start_i) begin
      pos_q <= '0; base_a_q <= '0; base_b_q <= '0;
    end else if (pix_valid_i) begin
      pos_q <= pos_q + POS_W'(1);
      if (pos_q == POS_W'(GROUP_PIX - 1)) begin
        base_a_q <= base_a_q + AW'(GROUP_PIX);
        base_b_q <= base_b_q + AW'(GROUP_PIX);
      end
    end
  end

  // window bypasses plane A fine scroll
  assign raddr[0] = base_a_q + AW'(pos_q) - (window_i ? AW'(0) : AW'(hscroll_a_i));
  assign raddr[1] = base_b_q + AW'(pos_q) - AW'(hscroll_b_i);

  for (genvar gp = 0; gp < 2; gp++) begin : g_plane
    lyr_line_buf #(.DEPTH(BUF_DEPTH)) u_buf (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && (wr_plane_b_i == 1'(gp))),
      .waddr_i (wr_addr_i),
      .wdata_i (pix_t'(wr_pix_i)),
      .raddr_i (raddr[gp]),
      .rdata_o (rdata[gp])
    );
  end

  logic [5:0] res_color;
  shade_e     res_shade;
  tag_t       res_tag;

  lyr_prio_resolve u_res (
    .sh_mode_i (sh_mode_i),
    .win_i     (window_i),
    .spr_i     (pix_t'(spr_pix_i)),
    .a_i       (rdata[0]),
    .b_i       (rdata[1]),
    .bg_i      (bg_color_i),
    .color_o   (res_color),
    .shade_o   (res_shade),
    .tag_o     (res_tag)
  );

  logic       valid_q;
  logic [5:0] cram_q;
  shade_e     shade_q;
  tag_t       tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0; cram_q <= '0; shade_q <= SHD_NORM; tag_q <= '0;
    end else begin
      valid_q <= pix_valid_i;
      if (pix_valid_i) begin
        cram_q  <= res_color;
        shade_q <= res_shade;
        tag_q   <= res_tag;
      end
    end
  end

  assign valid_o    = valid_q;
  assign cram_idx_o = cram_q;
  assign shade_o    = shade_q;
  assign tag_o      = tag_q;

  assert_transparent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && res_tag.src == SRC_SPR) |-> spr_pix_i[3:0] != 4'd0);
  assert_norm_shade_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !sh_mode_i) |=> shade_o == SHD_NORM);
  assert_op_hidden_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && sh_mode_i && spr_pix_i[5:1] == 5'h1F) |-> res_tag.src != SRC_SPR);
  assert_bases_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_a_q == base_b_q);
  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_i |=> valid_o);
  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_valid_i |=> !valid_o);
endmodule

// File: tb/tb_lyr_mixer.sv
module tb_lyr_mixer;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, line_start, wr_en, wr_b, pix_valid, sh_mode, window;
  logic [4:0] wr_addr;
  logic [6:0] wr_pix, spr;
  logic [3:0] hs_a, hs_b;
  logic [5:0] bg;
  logic       valid_o;
  logic [5:0] cram_o, tag_o;
  logic [1:0] shade_o;

  int n_chk = 0, n_fail = 0;

  lyr_mixer dut (
    .clk_i(clk), .rst_ni(rst_n), .line_start_i(line_start), .wr_en_i(wr_en),
    .wr_plane_b_i(wr_b), .wr_addr_i(wr_addr), .wr_pix_i(wr_pix),
    .pix_valid_i(pix_valid), .spr_pix_i(spr), .sh_mode_i(sh_mode),
    .window_i(window), .hscroll_a_i(hs_a), .hscroll_b_i(hs_b),
    .bg_color_i(bg), .valid_o(valid_o), .cram_idx_o(cram_o),
    .shade_o(shade_o), .tag_o(tag_o)
  );

  task automatic chk(string req, logic [13:0] got, logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // {colour[5:0], shade[1:0], light, dark, pri, src[2:0]}
  function automatic logic [13:0] ref_mix(input logic sh, input logic win,
      input logic [6:0] s, input logic [6:0] a, input logic [6:0] b, input logic [5:0] bgc);
    logic so, ao, bo, pw;
    logic [2:0] asrc, src;
    logic [5:0] col;
    logic [1:0] shd;
    logic pr;
    so = s[3:0] != 0; ao = a[3:0] != 0; bo = b[3:0] != 0;
    asrc = win ? 3'd2 : 3'd1;
    col = bgc; src = 3'd0; pr = 1'b0; pw = 1'b0;
    if (sh && (s[5:0] == 6'h3F || s[5:0] == 6'h3E)) begin
      shd = (s[5:0] == 6'h3F) ? 2'd1 : 2'd2;
      if (a[6] && ao)      begin col = a[5:0]; src = asrc; pr = 1; end
      else if (b[6] && bo) begin col = b[5:0]; src = 3'd3; pr = 1; end
      else if (ao)         begin col = a[5:0]; src = asrc; end
      else if (bo)         begin col = b[5:0]; src = 3'd3; end
    end else begin
      if (s[6] && so)      begin col = s[5:0]; src = 3'd4; pr = 1; pw = 1; end
      else if (a[6] && ao) begin col = a[5:0]; src = asrc; pr = 1; pw = 1; end
      else if (b[6] && bo) begin col = b[5:0]; src = 3'd3; pr = 1; pw = 1; end
      else if (so)         begin col = s[5:0]; src = 3'd4; end
      else if (ao)         begin col = a[5:0]; src = asrc; end
      else if (bo)         begin col = b[5:0]; src = 3'd3; end
      if (!sh || pw) shd = 2'd0;
      else if (src == 3'd4 && s[3:0] == 4'hE) shd = 2'd0;
      else shd = 2'd1;
    end
    return {col, shd, shd == 2'd2, shd == 2'd1, pr, src};
  endfunction

  function automatic logic [6:0] fill_val(input int i);
    logic [4:0] k;
    k = 5'(i);
    return {1'b0, k[4:3], 4'({1'b0, k[2:0]} + 4'd1)};
  endfunction

  task automatic mix_case(string req, logic sh, logic win, logic [6:0] s, logic [6:0] a, logic [6:0] b);
    @(negedge clk);
    line_start = 1; wr_en = 1; wr_b = 0; wr_addr = 0; wr_pix = a; hs_a = 0; hs_b = 0;
    @(negedge clk);
    line_start = 0; wr_b = 1; wr_pix = b;
    @(negedge clk);
    wr_en = 0; pix_valid = 1; spr = s; sh_mode = sh; window = win;
    @(negedge clk);
    pix_valid = 0;
    chk(req, {cram_o, shade_o, tag_o}, ref_mix(sh, win, s, a, b, bg));
    chk("R10 valid", {13'd0, valid_o}, 14'd1);
  endtask

  task automatic fill_plane(logic pb, logic zero);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wr_en = 1; wr_b = pb; wr_addr = 5'(i); wr_pix = zero ? 7'd0 : fill_val(i);
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic scroll_run(string req, logic pb, logic win, int sh_amt);
    int idx;
    @(negedge clk);
    line_start = 1; sh_mode = 0; window = win; spr = 0;
    hs_a = pb ? 4'd0 : 4'(sh_amt); hs_b = pb ? 4'(sh_amt) : 4'd0;
    for (int n = 0; n <= 48; n++) begin
      @(negedge clk);
      line_start = 0;
      pix_valid = (n < 48);
      if (n > 0) begin
        idx = (!pb && win) ? ((n - 1) & 31) : ((n - 1 - sh_amt) & 31);
        chk(req, {5'd0, cram_o, tag_o[2:0]},
            {5'd0, fill_val(idx)[5:0], pb ? 3'd3 : (win ? 3'd2 : 3'd1)});
      end
    end
  endtask

  logic [6:0] samp [8] = '{7'h00, 7'h40, 7'h05, 7'h45, 7'h2E, 7'h3E, 7'h3F, 7'h7E};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; line_start = 0; wr_en = 0; wr_b = 0; wr_addr = 0; wr_pix = 0;
    pix_valid = 0; spr = 0; sh_mode = 0; window = 0; hs_a = 0; hs_b = 0; bg = 6'h09;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset", {valid_o, cram_o, shade_o, tag_o, 1'b0}, 16'd0);

    // R1 transparent with priority and palette falls through to background
    mix_case("R1", 0, 0, 7'h70, 7'h40, 7'h30);
    chk("R1 bg", {cram_o, tag_o[2:0], 5'd0}, {6'h09, 3'd0, 5'd0});
    // R3 normal mode never shades, even for operator values
    mix_case("R3", 0, 0, 7'h3F, 7'h00, 7'h05);
    chk("R3 shade", {12'd0, shade_o}, 14'd0);
    // R9 window tag with priority flag
    mix_case("R9", 0, 1, 7'h00, 7'h45, 7'h00);
    chk("R9 tag", {8'd0, tag_o}, {8'd0, 6'b001010});
    // R10 idle cycle after the pixel
    @(negedge clk);
    chk("R10 idle", {13'd0, valid_o}, 14'd0);

    // sweep: mode x window x sprite x A x B
    for (int m = 0; m < 4; m++)
      for (int si = 0; si < 8; si++)
        for (int ai = 0; ai < 8; ai++)
          for (int bi = 0; bi < 8; bi++) begin
            logic shm;
            shm = m[1];
            if (!shm) mix_case("R2", 0, m[0], samp[si], samp[ai], samp[bi]);
            else if (samp[si][5:1] == 5'h1F) mix_case("R4", 1, m[0], samp[si], samp[ai], samp[bi]);
            else if (samp[si][3:0] == 4'hE) mix_case("R6", 1, m[0], samp[si], samp[ai], samp[bi]);
            else mix_case("R5", 1, m[0], samp[si], samp[ai], samp[bi]);
          end

    // R7 and R8: fine scroll, wrap, base stepping, line restart
    fill_plane(0, 0);
    fill_plane(1, 1);
    for (int s = 0; s < 16; s++) scroll_run("R7 plane A", 0, 0, s);
    for (int s = 0; s < 16; s += 5) scroll_run("R7 window", 0, 1, s);
    fill_plane(0, 1);
    fill_plane(1, 0);
    for (int s = 0; s < 16; s++) scroll_run("R8 plane B", 1, 0, s);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule